// File: doc/BRIEF.md
# Carry-Save Tree Multiplier Array

This block multiplies two unsigned operands of widths `A_W` and `B_W`. It first forms the AND-array partial products. It then reduces every bit column with its own compressor slice. All slices are built the same way, and each is as tall as the narrower operand. Inside a slice, layers of 3:2 counters lower the column height one level at a time. Every carry a counter makes goes sideways into the next more significant slice, at the next level down. The least significant slice takes zeros on its carry inputs. Columns with fewer partial products than the slice height are filled with zeros.

The reduced result leaves the block in redundant form as two vectors of equal weight, `sumVec` and `carryVec`. Setting `FINAL_ADD` adds them into a plain `product`. `PIPE_AFTER` places a register bank across every slice after the given counter level, so all columns are cut at the same depth. `OUT_REG` registers the outputs. `inValid` travels alongside the data to `outValid`, and each register bank loads only on a valid beat.

Top module: `csa_tree_mult`

## Requirements
- R1: When `outValid` is high, `product` equals the unsigned product `opA * opB` of the beat that produced it, as `A_W+B_W` bits.
- R2: When `outValid` is high, `sumVec + carryVec` taken modulo 2^(A_W+B_W) equals the same product, and the true (unreduced) sum of the two vectors is below 2^(A_W+B_W).
- R3: The result of a beat appears exactly LAT cycles after it is presented, where LAT = (PIPE_AFTER > 0) + OUT_REG (2 at defaults). `outValid` at a cycle equals `inValid` LAT cycles earlier.
- R4: A cycle with `inValid` low produces a cycle LAT later with `outValid` low.
- R5: With `OUT_REG` set, `product`, `sumVec` and `carryVec` hold their last valid values through cycles where `outValid` is low.
- R6: While `rstN` is low, `outValid` is 0 and `product`, `sumVec` and `carryVec` are all zero.
- R7: A zero operand produces zero on `product`, `sumVec` and `carryVec`.
- R8: Bit A_W+B_W-1 of `carryVec` is always 0. Bit A_W+B_W-1 of `sumVec` gathers the lateral carries that leave the top slice, and at most one of them is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands on this cycle are a beat to multiply |
| opA | input | A_W | Unsigned operand A |
| opB | input | B_W | Unsigned operand B |
| outValid | output | 1 | Outputs carry the result of a beat |
| sumVec | output | A_W+B_W | Redundant result, first vector |
| carryVec | output | A_W+B_W | Redundant result, second vector, same bit weights |
| product | output | A_W+B_W | Sum of both vectors (zero when FINAL_ADD is 0) |

## Verification
The latency and product assertions assume that `opA`, `opB` and `inValid` never carry X or Z. They also assume `inValid` is held low while reset is applied. The spill assertion depends on the register bank holding either the reset zeros or the image of a single real beat, and is never fed a mix of unrelated bits. The bench drives every operand pair of the default 6x5 configuration as known values on falling edges, so all zero, all-ones and single-bit patterns are covered. It keeps `inValid` low throughout reset and inserts regular bubbles between beats.

// File: rtl/mult_pkg.sv
package mult_pkg;

  typedef struct packed {
    logic stageLoad;
    logic outLoad;
  } strobe_t;

  function automatic int levelHeight(input int k, input int lvl);
    int h;
    h = k;
    for (int i = 0; i < lvl; i++) begin
      if (h > 2) h = h - h / 3;
    end
    return h;
  endfunction

  function automatic int levelCount(input int k);
    int h;
    int n;
    h = k;
    n = 0;
    while (h > 2) begin
      h = h - h / 3;
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/fa3.sv
module fa3 (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int HAS_PIPE = 1,
  parameter int OUT_REG  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strb,
  output logic    outValid
);
  localparam int LAT = HAS_PIPE + OUT_REG;

  logic midValid;

  generate
    if (HAS_PIPE != 0) begin : g_pipe
      logic vMid;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vMid <= 1'b0;
        else       vMid <= inValid;
      end
      assign midValid = vMid;
    end else begin : g_nopipe
      assign midValid = inValid;
    end

    if (OUT_REG != 0) begin : g_oreg
      logic vOut;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vOut <= 1'b0;
        else       vOut <= midValid;
      end
      assign outValid = vOut;
    end else begin : g_noreg
      assign outValid = midValid;
    end
  endgenerate

  assign strb.stageLoad = inValid;
  assign strb.outLoad   = midValid;

  // cycles since reset, saturating; guards the latency check
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  generate
    if (LAT == 1) begin : g_a1
      assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd1) |-> (outValid == $past(inValid, 1)));
    end else if (LAT == 2) begin : g_a2
      assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));
    end
  endgenerate
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath
  import mult_pkg::*;
#(
  parameter int A_W        = 6,
  parameter int B_W        = 5,
  parameter int PIPE_AFTER = 2,
  parameter int OUT_REG    = 1,
  parameter int FINAL_ADD  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic [A_W+B_W-1:0] sumVec,
  output logic [A_W+B_W-1:0] carryVec,
  output logic [A_W+B_W-1:0] product
);
  localparam int W    = A_W + B_W;
  localparam int COLS = W - 1;
  localparam int K    = (A_W <= B_W) ? A_W : B_W;
  localparam int BIG  = (A_W <= B_W) ? B_W : A_W;
  localparam int LV   = levelCount(K);
  localparam int LVA  = (LV > 0) ? LV : 1;

  logic [K-1:0]   smallOp;
  logic [BIG-1:0] bigOp;

  generate
    if (A_W <= B_W) begin : g_selA
      assign smallOp = opA;
      assign bigOp   = opB;
    end else begin : g_selB
      assign smallOp = opB;
      assign bigOp   = opA;
    end
  endgenerate

  logic [K-1:0] lv   [LV+1][COLS];   // level outputs, padded to slice height
  logic [K-1:0] lvIn [LV+1][COLS];   // level inputs, after optional stage bank
  logic [K-1:0] cy   [LVA][COLS];    // lateral carries out of each slice
  logic [LVA-1:0] topOr;

  // partial product array, zero padded per column
  generate
    for (genvar c = 0; c < COLS; c++) begin : g_ppCol
      for (genvar r = 0; r < K; r++) begin : g_ppRow
        if ((c - r >= 0) && (c - r < BIG)) begin : g_on
          assign lv[0][c][r] = smallOp[r] & bigOp[c-r];
        end else begin : g_off
          assign lv[0][c][r] = 1'b0;
        end
      end
    end
  endgenerate

  // optional register bank across all slices
  generate
    if (PIPE_AFTER > 0 && PIPE_AFTER <= LV) begin : g_stage
      logic [K-1:0] stageQ [COLS];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int c = 0; c < COLS; c++) stageQ[c] <= '0;
        end else if (strb.stageLoad) begin
          for (int c = 0; c < COLS; c++) stageQ[c] <= lv[PIPE_AFTER][c];
        end
      end
      for (genvar L = 0; L <= LV; L++) begin : g_lvSel
        for (genvar c = 0; c < COLS; c++) begin : g_colSel
          if (L == PIPE_AFTER) begin : g_reg
            assign lvIn[L][c] = stageQ[c];
          end else begin : g_comb
            assign lvIn[L][c] = lv[L][c];
          end
        end
      end
    end else begin : g_noStage
      for (genvar L = 0; L <= LV; L++) begin : g_lvSel
        for (genvar c = 0; c < COLS; c++) begin : g_colSel
          assign lvIn[L][c] = lv[L][c];
        end
      end
    end
  endgenerate

  // identical slices, one counter layer per level
  generate
    if (LV == 0) begin : g_noLv
      for (genvar c = 0; c < COLS; c++) begin : g_z
        assign cy[0][c] = '0;
      end
      assign topOr = '0;
    end
    for (genvar L = 0; L < LV; L++) begin : g_lvl
      localparam int HL = levelHeight(K, L);
      localparam int FL = HL / 3;
      for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < K; r++) begin : g_row
          if (r < FL) begin : g_fa
            fa3 u_fa (
              .x(lvIn[L][c][3*r]),
              .y(lvIn[L][c][3*r+1]),
              .z(lvIn[L][c][3*r+2]),
              .s(lv[L+1][c][r]),
              .c(cy[L][c][r])
            );
          end else begin : g_noFa
            assign cy[L][c][r] = 1'b0;
            if (r < 2 * FL) begin : g_cin
              if (c == 0) begin : g_lsb
                assign lv[L+1][c][r] = 1'b0;
              end else begin : g_nb
                assign lv[L+1][c][r] = cy[L][c-1][r-FL];
              end
            end else if (r < HL - FL) begin : g_pass
              assign lv[L+1][c][r] = lvIn[L][c][r+FL];
            end else begin : g_pad
              assign lv[L+1][c][r] = 1'b0;
            end
          end
        end
      end
      assign topOr[L] = |cy[L][COLS-1];
    end
  endgenerate

  // carries leaving the top slice land in the spill bit
  logic spillPre;
  logic spillPost;
  always_comb begin
    spillPre  = 1'b0;
    spillPost = 1'b0;
    for (int L = 0; L < LV; L++) begin
      if (L < PIPE_AFTER) spillPre  = spillPre  | topOr[L];
      else                spillPost = spillPost | topOr[L];
    end
  end

  logic spillHeld;
  generate
    if (PIPE_AFTER > 0 && PIPE_AFTER <= LV) begin : g_spillReg
      logic spillQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                spillQ <= 1'b0;
        else if (strb.stageLoad)  spillQ <= spillPre;
      end
      assign spillHeld = spillQ;
    end else begin : g_spillComb
      assign spillHeld = spillPre;
    end
  endgenerate

  logic [W-1:0] sumNext;
  logic [W-1:0] carryNext;
  logic [W-1:0] prodNext;

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      sumNext[c]   = lvIn[LV][c][0];
      carryNext[c] = lvIn[LV][c][1];
    end
    sumNext[W-1]   = spillHeld | spillPost;
    carryNext[W-1] = 1'b0;
  end

  generate
    if (FINAL_ADD != 0) begin : g_add
      assign prodNext = sumNext + carryNext;
    end else begin : g_noAdd
      assign prodNext = '0;
    end

    if (OUT_REG != 0) begin : g_out
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sumVec   <= '0;
          carryVec <= '0;
          product  <= '0;
        end else if (strb.outLoad) begin
          sumVec   <= sumNext;
          carryVec <= carryNext;
          product  <= prodNext;
        end
      end
    end else begin : g_noOut
      assign sumVec   = sumNext;
      assign carryVec = carryNext;
      assign product  = prodNext;
    end
  endgenerate

  assert_spill_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(spillHeld && spillPost));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, sumNext} + {1'b0, carryNext}) < {1'b1, {W{1'b0}}});
endmodule

// File: rtl/csa_tree_mult.sv
module csa_tree_mult
  import mult_pkg::*;
#(
  parameter int A_W        = 6,
  parameter int B_W        = 5,
  parameter int PIPE_AFTER = 2,
  parameter int OUT_REG    = 1,
  parameter int FINAL_ADD  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [A_W-1:0]     opA,
  input  logic [B_W-1:0]     opB,
  output logic               outValid,
  output logic [A_W+B_W-1:0] sumVec,
  output logic [A_W+B_W-1:0] carryVec,
  output logic [A_W+B_W-1:0] product
);
  localparam int W        = A_W + B_W;
  localparam int K        = (A_W <= B_W) ? A_W : B_W;
  localparam int HAS_PIPE = (PIPE_AFTER > 0 && PIPE_AFTER <= levelCount(K)) ? 1 : 0;
  localparam int LAT      = HAS_PIPE + ((OUT_REG != 0) ? 1 : 0);

  strobe_t strb;

  mult_ctrl #(.HAS_PIPE(HAS_PIPE), .OUT_REG((OUT_REG != 0) ? 1 : 0)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  mult_datapath #(
    .A_W(A_W), .B_W(B_W), .PIPE_AFTER(PIPE_AFTER),
    .OUT_REG(OUT_REG), .FINAL_ADD(FINAL_ADD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .sumVec(sumVec), .carryVec(carryVec), .product(product)
  );

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  generate
    if (FINAL_ADD != 0 && LAT == 2) begin : g_chk2
      assert_product_R1: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd2 && outValid) |->
        (product == ({{B_W{1'b0}}, $past(opA, 2)} * {{A_W{1'b0}}, $past(opB, 2)})));
    end else if (FINAL_ADD != 0 && LAT == 1) begin : g_chk1
      assert_product_R1: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd1 && outValid) |->
        (product == ({{B_W{1'b0}}, $past(opA, 1)} * {{A_W{1'b0}}, $past(opB, 1)})));
    end
  endgenerate

  assert_carry_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    carryVec[W-1] == 1'b0);
endmodule

// File: tb/sim_csa_tree_mult.sv
module sim_csa_tree_mult;
  localparam int A_W = 6;
  localparam int B_W = 5;
  localparam int W = A_W + B_W;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;                 // pipe stage + output register (R3)
  localparam int MAXCYC = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [A_W-1:0] opA = '0;
  logic [B_W-1:0] opB = '0;
  logic outValid;
  logic [W-1:0] sumVec, carryVec, product;

  int checks = 0;
  int errors = 0;
  bit expV [MAXCYC];
  logic [W-1:0] expP [MAXCYC];
  logic [W-1:0] lastP;
  logic [W-1:0] lastS;
  logic [W-1:0] lastC;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_tree_mult #(.A_W(A_W), .B_W(B_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .sumVec(sumVec), .carryVec(carryVec), .product(product)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sampleAt(input int t);
    logic [W:0] rsum;
    if (t < LAT) return;
    chk(outValid == expV[t-LAT], "R3/R4 outValid", {{(W-1){1'b0}}, outValid}, {{(W-1){1'b0}}, expV[t-LAT]});
    if (expV[t-LAT]) begin
      rsum = {1'b0, sumVec} + {1'b0, carryVec};
      chk(product == expP[t-LAT], "R1 product", product, expP[t-LAT]);
      chk(rsum == {1'b0, expP[t-LAT]}, "R2 redundant sum", rsum[W-1:0], expP[t-LAT]);
      chk(carryVec[W-1] == 1'b0, "R8 carry top bit", carryVec, '0);
      if (expP[t-LAT] == '0)
        chk(sumVec == '0 && carryVec == '0, "R7 zero operand vectors", sumVec | carryVec, '0);
      lastP = product; lastS = sumVec; lastC = carryVec;
    end else if (t > LAT) begin
      chk(product == lastP && sumVec == lastS && carryVec == lastC, "R5 hold in bubble", product, lastP);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t;
    int a;
    int b;
    lastP = '0; lastS = '0; lastC = '0;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R6 reset outValid", {{(W-1){1'b0}}, outValid}, '0);
    chk(product == '0 && sumVec == '0 && carryVec == '0, "R6 reset outputs", product | sumVec | carryVec, '0);
    rstN = 1'b1;
    t = 0; a = 0; b = 0;
    while (a < (1 << A_W) || t < 4) begin
      @(negedge clk);
      sampleAt(t);
      if (a < (1 << A_W) && (t % 5) != 4) begin
        inValid = 1'b1;
        opA = a[A_W-1:0];
        opB = b[B_W-1:0];
        expV[t] = 1'b1;
        expP[t] = W'(a * b);
        b++;
        if (b == (1 << B_W)) begin b = 0; a++; end
      end else begin
        inValid = 1'b0;
        opA = '1;                           // bubble operands must not show (R4)
        opB = '1;
        expV[t] = 1'b0;
        expP[t] = '0;
      end
      t++;
    end
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      sampleAt(t);
      inValid = 1'b0;
      expV[t] = 1'b0;
      expP[t] = '0;
      t++;
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule